// File: doc/BRIEF.md
# Randomized Decoupling-Capacitor Switch Scheduler

This block drives the gate lines of a bank of equal-value switched decoupling capacitors that sit on the supply path of side-channel-sensitive logic. Each time the protected logic starts a new input vector, a one-cycle strobe arrives together with a random word. The block turns that word into one subset of exactly K capacitors out of N and connects those capacitors to the supply until the next strobe. The switches are PMOS devices, so every enable output is active low.

A static parameter picks the network shape. The tree shape has three capacitors, two of them connected per vector (3 possible subsets). The grid shape has ten capacitors, four of them connected per vector (210 possible subsets). The random word is reduced modulo the number of subsets. The resulting index is decoded by combinational unranking into a K-hot mask. The mask is registered on the strobe. A population monitor watches the registered enables and raises a flag if the number of connected capacitors is ever different from K.

Top module: `decap_sched`

## Requirements
- R1: After reset, every enable output is 1 (all capacitors disconnected) and the error flag is 0. This holds until the first strobe.
- R2: On a clock edge where `vec_stb` is 1, the enables take a new value that is valid from that edge on. The value depends only on `rand_word` sampled at that edge.
- R3: After any strobe, exactly K enable outputs are 0: two of three in the tree shape (`GRID`=0) and four of ten in the grid shape (`GRID`=1).
- R4: On edges where `vec_stb` is 0, the enables keep their value, whatever `rand_word` does.
- R5: The subset index is `rand_word` mod C(N,K). If the connected capacitors sit at bit positions p1<p2<...<pK, the index equals the sum over j of C(pj, j).
- R6: Every index from 0 to C(N,K)-1 selects a different subset, so all 3 (tree) or 210 (grid) subsets are reachable.
- R7: Values of `rand_word` at or above C(N,K) wrap: w and w mod C(N,K) select the same subset, including the all-ones word.
- R8: `cnt_err` is 1 in any cycle after the first strobe in which the number of 0 enables differs from K. It is 0 before the first strobe.
- R9: A logic 0 on bit i of `sw_en_n` connects capacitor i and a logic 1 disconnects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vec_stb | input | 1 | One-cycle pulse marking a new input vector |
| rand_word | input | RAND_W | Random word sampled with the strobe |
| sw_en_n | output | NCAP | Active-low PMOS switch enables, one per capacitor |
| cnt_err | output | 1 | Connected-count differs from K after the first strobe |

## Verification
On every cycle, the assertions check four properties: the K-hot count after each strobe, hold of the enables between strobes, the idle all-high state before the first strobe, and the absence of a raised count flag. Only the bench scenarios can show that the mapping from word to subset is correct. To do so, the bench recovers the index from the observed mask and compares it with the word reduced modulo C(N,K). It does this over every index of both shapes, on wrap-around words, and with the random word changing while no strobe is present.

// File: rtl/decap_pkg.sv
`timescale 1ns/1ps
package decap_pkg;

  function automatic int unsigned cap_count(input bit grid);
    return grid ? 10 : 3;
  endfunction

  function automatic int unsigned sel_count(input bit grid);
    return grid ? 4 : 2;
  endfunction

  // n choose k, built by exact stepwise products
  function automatic int unsigned binom(input int unsigned n, input int unsigned k);
    int unsigned r;
    if (k > n) return 0;
    r = 1;
    for (int unsigned s = 0; s < k; s++) r = r * (n - s) / (s + 1);
    return r;
  endfunction

endpackage

// File: rtl/decap_rst_sync.sv
`timescale 1ns/1ps
module decap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/decap_idx_reduce.sv
`timescale 1ns/1ps
module decap_idx_reduce #(
  parameter int unsigned RAND_W = 16,
  parameter int unsigned NCOMB  = 210,
  parameter int unsigned IDX_W  = 8
) (
  input  logic [RAND_W-1:0] rand_word,
  output logic [IDX_W-1:0]  idx
);
  logic [31:0] wide_word;
  logic [31:0] wide_idx;

  assign wide_word = 32'(rand_word);
  assign wide_idx  = wide_word % NCOMB;
  assign idx       = wide_idx[IDX_W-1:0];
endmodule

// File: rtl/decap_unrank.sv
`timescale 1ns/1ps
module decap_unrank #(
  parameter int unsigned NCAP  = 10,
  parameter int unsigned KSEL  = 4,
  parameter int unsigned IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [NCAP-1:0]  mask
);
  // Greedy combinadic decode: scan from the top position downward and
  // take position i whenever the remaining rank reaches C(i, left).
  always_comb begin
    int unsigned rem;
    int unsigned left;
    int unsigned thr;
    rem  = 32'(idx);
    left = KSEL;
    mask = '0;
    for (int i = int'(NCAP) - 1; i >= 0; i--) begin
      thr = 0;
      for (int kk = 1; kk <= int'(KSEL); kk++) begin
        if (left == unsigned'(kk)) thr = decap_pkg::binom(unsigned'(i), unsigned'(kk));
      end
      if (left != 0 && rem >= thr) begin
        mask[i] = 1'b1;
        rem     = rem - thr;
        left    = left - 1;
      end
    end
  end
endmodule

// File: rtl/decap_enreg.sv
`timescale 1ns/1ps
module decap_enreg #(
  parameter int unsigned NCAP = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NCAP-1:0] mask,
  output logic [NCAP-1:0] sw_en_n,
  output logic            armed
);
  logic [NCAP-1:0] en_n_q, en_n_nxt;
  logic            armed_q, armed_nxt;

  always_comb begin
    en_n_nxt  = en_n_q;
    armed_nxt = armed_q;
    if (load) begin
      en_n_nxt  = ~mask;
      armed_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_n_q  <= '1;
      armed_q <= 1'b0;
    end else begin
      en_n_q  <= en_n_nxt;
      armed_q <= armed_nxt;
    end
  end

  assign sw_en_n = en_n_q;
  assign armed   = armed_q;
endmodule

// File: rtl/decap_popcheck.sv
`timescale 1ns/1ps
module decap_popcheck #(
  parameter int unsigned NCAP = 10,
  parameter int unsigned KSEL = 4
) (
  input  logic            armed,
  input  logic [NCAP-1:0] sw_en_n,
  output logic            cnt_err
);
  localparam int unsigned CNT_W = $clog2(NCAP + 1);

  logic [CNT_W-1:0] on_cnt;

  always_comb begin
    on_cnt = '0;
    for (int i = 0; i < int'(NCAP); i++) begin
      if (!sw_en_n[i]) on_cnt = on_cnt + 1'b1;
    end
  end

  assign cnt_err = armed && (on_cnt != CNT_W'(KSEL));
endmodule

// File: rtl/decap_sched.sv
`timescale 1ns/1ps
module decap_sched #(
  parameter bit          GRID   = 1'b1,
  parameter int unsigned RAND_W = 16,
  localparam int unsigned NCAP  = decap_pkg::cap_count(GRID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_stb,
  input  logic [RAND_W-1:0] rand_word,
  output logic [NCAP-1:0]   sw_en_n,
  output logic              cnt_err
);
  localparam int unsigned KSEL  = decap_pkg::sel_count(GRID);
  localparam int unsigned NCOMB = decap_pkg::binom(NCAP, KSEL);
  localparam int unsigned IDX_W = $clog2(NCOMB);

  logic             rst_sync_n;
  logic [IDX_W-1:0] sel_idx;
  logic [NCAP-1:0]  sel_mask;
  logic             armed;

  decap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  decap_idx_reduce #(.RAND_W(RAND_W), .NCOMB(NCOMB), .IDX_W(IDX_W)) u_reduce (
    .rand_word (rand_word),
    .idx       (sel_idx)
  );

  decap_unrank #(.NCAP(NCAP), .KSEL(KSEL), .IDX_W(IDX_W)) u_unrank (
    .idx  (sel_idx),
    .mask (sel_mask)
  );

  decap_enreg #(.NCAP(NCAP)) u_enreg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (vec_stb),
    .mask    (sel_mask),
    .sw_en_n (sw_en_n),
    .armed   (armed)
  );

  decap_popcheck #(.NCAP(NCAP), .KSEL(KSEL)) u_pop (
    .armed   (armed),
    .sw_en_n (sw_en_n),
    .cnt_err (cnt_err)
  );
endmodule

// File: rtl/decap_sched_chk.sv
`timescale 1ns/1ps
module decap_sched_chk #(
  parameter bit          GRID = 1'b1,
  parameter int unsigned NCAP = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vec_stb,
  input logic [NCAP-1:0] sw_en_n,
  input logic            cnt_err
);
  localparam int unsigned KSEL = decap_pkg::sel_count(GRID);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (vec_stb) seen_q <= 1'b1;
  end

  AST_K_HOT_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |=> ($countones(~sw_en_n) == KSEL)); // R3
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_stb && seen_q) |=> $stable(sw_en_n)); // R4
  AST_IDLE_BEFORE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (&sw_en_n)); // R1
  AST_ERR_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !cnt_err); // R8
  AST_NO_COUNT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> !cnt_err); // R8
endmodule

bind decap_sched decap_sched_chk #(.GRID(GRID), .NCAP(NCAP)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .vec_stb (vec_stb),
  .sw_en_n (sw_en_n),
  .cnt_err (cnt_err)
);

// File: tb/test_decap_sched.sv
`timescale 1ns/1ps
module test_decap_sched;
  logic        clk;
  logic        rst_n;
  logic        vec_stb;
  logic [15:0] rand_word;
  logic [9:0]  en_g;
  logic [2:0]  en_t;
  logic        err_g, err_t;

  int n_chk;
  int n_bad;
  bit done;

  decap_sched #(.GRID(1'b1), .RAND_W(16)) i_decap_sched (
    .clk(clk), .rst_n(rst_n), .vec_stb(vec_stb), .rand_word(rand_word),
    .sw_en_n(en_g), .cnt_err(err_g)
  );

  decap_sched #(.GRID(1'b0), .RAND_W(16)) i_decap_sched_tree (
    .clk(clk), .rst_n(rst_n), .vec_stb(vec_stb), .rand_word(rand_word),
    .sw_en_n(en_t), .cnt_err(err_t)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Pascal-rule binomial, independent of the design's formula
  function automatic int choose(input int n, input int k);
    if (k < 0 || k > n) return 0;
    if (k == 0 || k == n) return 1;
    return choose(n - 1, k - 1) + choose(n - 1, k);
  endfunction

  function automatic int rank_of(input logic [9:0] on_mask, input int n);
    int j;
    int r;
    j = 0;
    r = 0;
    for (int p = 0; p < n; p++) begin
      if (on_mask[p]) begin
        j = j + 1;
        r = r + choose(p, j);
      end
    end
    return r;
  endfunction

  function automatic int ones_of(input logic [9:0] v, input int n);
    int c;
    c = 0;
    for (int p = 0; p < n; p++) if (v[p]) c++;
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    vec_stb   = 1'b1;
    rand_word = w;
    @(negedge clk);
    vec_stb   = 1'b0;
  endtask

  // checks both shapes against word w; R3, R5, R9
  task automatic check_vec(input logic [15:0] w, input string req);
    logic [9:0] on_g;
    logic [9:0] on_t;
    on_g = ~en_g;
    on_t = {7'b0, ~en_t};
    chk(ones_of(on_g, 10) == 4, "R3", "grid connected count", ones_of(on_g, 10), 4);
    chk(ones_of(on_t, 3) == 2, "R3", "tree connected count", ones_of(on_t, 3), 2);
    chk(rank_of(on_g, 10) == int'(w) % 210, req, "grid index", rank_of(on_g, 10), int'(w) % 210);
    chk(rank_of(on_t, 3) == int'(w) % 3, req, "tree index", rank_of(on_t, 3), int'(w) % 3);
    chk(!err_g && !err_t, "R8", "count flag in operation", {err_g, err_t}, 0);
  endtask

  task automatic t_reset;
    rst_n     = 1'b0;
    vec_stb   = 1'b0;
    rand_word = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rand_word = 16'h1234;
    repeat (3) @(negedge clk);
    chk(en_g == 10'h3FF, "R1", "grid enables idle", en_g, 10'h3FF);
    chk(en_t == 3'h7, "R1", "tree enables idle", en_t, 3'h7);
    chk(!err_g && !err_t, "R8", "flag quiet before strobe", {err_g, err_t}, 0);
  endtask

  task automatic t_basic;
    logic [15:0] pats [5] = '{16'd0, 16'd1, 16'd77, 16'd209, 16'h5A5A};
    foreach (pats[i]) begin
      apply(pats[i]);
      check_vec(pats[i], "R2");
    end
    // active-low: index 0 picks the lowest positions p=0..K-1
    apply(16'd0);
    chk(en_g == 10'b1111110000, "R9", "grid index 0 pattern", en_g, 10'b1111110000);
    chk(en_t == 3'b100, "R9", "tree index 0 pattern", en_t, 3'b100);
  endtask

  task automatic t_hold;
    logic [9:0] g0;
    logic [2:0] t0;
    apply(16'd123);
    g0 = en_g;
    t0 = en_t;
    for (int c = 0; c < 6; c++) begin
      rand_word = 16'(c * 911 + 5);
      @(negedge clk);
      chk(en_g == g0, "R4", "grid held without strobe", en_g, g0);
      chk(en_t == t0, "R4", "tree held without strobe", en_t, t0);
    end
  endtask

  task automatic t_wrap;
    logic [9:0] g0;
    logic [2:0] t0;
    apply(16'd0);
    g0 = en_g;
    t0 = en_t;
    apply(16'd210);
    chk(en_g == g0, "R7", "grid 210 wraps to 0", en_g, g0);
    apply(16'd3);
    chk(en_t == t0, "R7", "tree 3 wraps to 0", en_t, t0);
    apply(16'hFFFF);
    check_vec(16'hFFFF, "R7");
    apply(16'd425);
    check_vec(16'd425, "R7");
  endtask

  task automatic t_sweep;
    for (int r = 0; r < 210; r++) begin
      apply(16'(r));
      check_vec(16'(r), "R6");
    end
    // back-to-back strobes, new word every cycle
    @(negedge clk);
    vec_stb = 1'b1;
    for (int r = 0; r < 8; r++) begin
      rand_word = 16'(r * 37 + 11);
      @(negedge clk);
      check_vec(16'(r * 37 + 11), "R2");
    end
    vec_stb = 1'b0;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    t_reset();
    t_basic();
    t_hold();
    t_wrap();
    t_sweep();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule